// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This block is a bus-attached timer with a parameterised number of independent down-counters (four by default) and one shared interrupt block. Software programs each channel through a start value, a reload value that is used only at the next wrap, and a control word. The control word chooses the counting width (16 or 32 bits), a clock prescaler, and one of three ways of behaving when the count runs out. In free-running mode the counter wraps to all ones. In periodic mode it reloads. In one-shot mode it parks at zero. Because the counters count downward, software that needs a rising time base reads the current value and inverts it.

Each channel posts an event to a raw-status bit when its count runs out. A mask register selects which raw bits reach the single interrupt output. Software acknowledges an event by writing a one to the matching bit of the clear register. All registers sit behind a single-cycle interface: a write takes effect at the clock edge on which `wr_en` is high, and `rdata` follows `addr` combinationally.

Each channel is run by a three-state machine. OFF holds the count. COUNT decrements it once per prescaler tick. DONE is the parked one-shot state. Its transitions are:
- OFF→COUNT, when the enable bit is set.
- COUNT→OFF and DONE→OFF, when the enable bit is cleared.
- COUNT→DONE, when a one-shot channel runs out.
- DONE→COUNT, when the load register is written.

Top module: `mct_timer_unit`

## Requirements
- R1: After reset every register reads zero, every channel is in OFF and `irq_o` is low.
- R2: Global registers sit at fixed offsets: mask at 0x00, raw status at 0x04, masked status at 0x08, and the write-only clear register at 0x0C, which reads zero. Channel n has its base at 0x10+0x10*n, with load at +0x0, current value at +0x4, control at +0x8 and reload at +0xC. The load and reload offsets both read back the stored reload value. Control keeps only bits 7, 6, 3:2, 1 and 0, and its other bits read zero.
- R3: Writing the load register sets the count to the written value at that clock edge and also copies the value into the reload register. A load write also restarts the prescaler.
- R4: Writing the reload register leaves the running count unchanged and changes only the value used at the next periodic reload.
- R5: While enabled (control bit 7), a channel decrements once per tick. With prescale code 00 (bits 3:2) a tick comes every cycle. Code 01 gives one every 16 cycles, and codes 10 and 11 give one every 256 cycles. The first tick after enabling, or after a load write, falls on the 1st, 16th or 256th cycle.
- R6: A tick that finds the count at zero sets raw-status bit n of that channel. A load value L therefore produces its event L+1 ticks after counting starts.
- R7: On that event, periodic mode (bit 6 set, bit 0 clear) reloads the count from the reload register. Free-running mode (bits 6 and 0 clear) wraps the count to all ones of the selected width.
- R8: In one-shot mode (bit 0 set) the event moves the channel to DONE. The count then stays at zero and raises no further events until the load register is written, which resumes counting.
- R9: With control bit 1 clear, the channel works in 16 bits: the current value reads back only its low 16 bits, zero is detected on those bits, and a free-running wrap gives 0xFFFF. With bit 1 set, all 32 bits are used.
- R10: Clearing the enable bit freezes the count at its current value.
- R11: The masked status equals raw status AND mask, and `irq_o` is high exactly when any masked-status bit is set.
- R12: Writing a one to a bit of the clear register clears that raw bit. If an event arrives for the same channel in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, applied at the rising edge |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | OR of the masked-status bits |

## Verification
The hardest situations to reach from the ports are a clear write that lands in the same cycle as a new event, and the long prescaled waits to a divide-by-256 tick. The first is reached by running a periodic channel with a zero load value, which makes it raise an event on every cycle, so any clear write collides with a set. The prescaler cases use directed loads with cycle-exact sampling just before and just on the expected tick. Random loads and modes, driven from a fixed seed, then probe the event timing L+1 and the value left after the wrap.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int PRE_W    = 8;
    localparam int CTL_W    = 8;

    localparam int CB_EN    = 7;
    localparam int CB_PER   = 6;
    localparam int CB_PSHI  = 3;
    localparam int CB_PSLO  = 2;
    localparam int CB_WIDE  = 1;
    localparam int CB_ONE   = 0;
    localparam logic [CTL_W-1:0] CTL_KEEP = 8'hCF;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_DONE  = 2'd2
    } ch_state_t;
endpackage

// File: rtl/mct_channel.sv
module mct_channel
    import mct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic              bg_we,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] bg_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              evt_o
);
    ch_state_t         state_q, state_d;
    logic [DATA_W-1:0] cnt_q, bg_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [PRE_W-1:0]  pre_q;
    logic              en_nx, tick, is_zero, wide;
    logic [DATA_W-1:0] cnt_m, wrap_val;

    assign wide     = ctl_q[CB_WIDE];
    assign cnt_m    = wide ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};
    assign is_zero  = (cnt_m == '0);
    assign wrap_val = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign en_nx    = ctl_we ? wdata[CB_EN] : ctl_q[CB_EN];

    always_comb begin
        tick = 1'b0;
        if (state_q == CH_COUNT && !ld_we) begin
            unique case (ctl_q[CB_PSHI:CB_PSLO])
                2'b00:   tick = 1'b1;
                2'b01:   tick = (pre_q[3:0] == 4'hF);
                default: tick = (pre_q == {PRE_W{1'b1}});
            endcase
        end
    end

    assign evt_o = tick && is_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   if (en_nx) state_d = CH_COUNT;
            CH_COUNT: if (!en_nx) state_d = CH_OFF;
                      else if (evt_o && ctl_q[CB_ONE]) state_d = CH_DONE;
            CH_DONE:  if (!en_nx) state_d = CH_OFF;
                      else if (ld_we) state_d = CH_COUNT;
            default:  state_d = CH_OFF;
        endcase
    end

    // datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bg_q  <= '0;
            ctl_q <= '0;
            pre_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
            pre_q <= (state_q == CH_COUNT && !ld_we) ? pre_q + 1'b1 : '0;
            if (ld_we) begin
                cnt_q <= wdata;
                bg_q  <= wdata;
            end else begin
                if (bg_we) bg_q <= wdata;
                if (tick) begin
                    if (!is_zero)            cnt_q <= cnt_q - 1'b1;
                    else if (ctl_q[CB_ONE])  cnt_q <= cnt_q;
                    else if (ctl_q[CB_PER])  cnt_q <= bg_q;
                    else                     cnt_q <= wrap_val;
                end
            end
        end
    end

    assign cnt_o = cnt_m;
    assign bg_o  = bg_q;
    assign ctl_o = ctl_q;

    // R3
    load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (cnt_q == $past(wdata)) && (bg_q == $past(wdata)));
    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !is_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DONE && !ld_we) |=> $stable(cnt_q));
    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF && !ld_we) |=> $stable(cnt_q));
endmodule

// File: rtl/mct_irq.sv
module mct_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] evt,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] raw_o,
    output logic           irq_o
);
    logic [NCH-1:0] mask_q, raw_q, clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            raw_q <= (raw_q & ~clr_bits) | evt;
        end
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;
    assign irq_o  = |(raw_q & mask_q);

    // R6
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));
    // R12
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(wbits & ~evt)) == '0));
endmodule

// File: rtl/mct_timer_unit.sv
module mct_timer_unit
    import mct_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        word;
    logic [NCH-1:0]    evt, mask, raw;
    logic [DATA_W-1:0] cnt [NCH];
    logic [DATA_W-1:0] bg  [NCH];
    logic [CTL_W-1:0]  ctl [NCH];

    assign slot = addr[ADDR_W-1:4];
    assign word = addr[3:2];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (slot == SLOT_W'(i + 1));
        mct_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld_we  (hit && word == 2'd0),
            .bg_we  (hit && word == 2'd3),
            .ctl_we (hit && word == 2'd2),
            .wdata  (wdata),
            .cnt_o  (cnt[i]),
            .bg_o   (bg[i]),
            .ctl_o  (ctl[i]),
            .evt_o  (evt[i])
        );
    end

    mct_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr_en && slot == '0 && word == 2'd0),
        .clr_we  (wr_en && slot == '0 && word == 2'd3),
        .wbits   (wdata[NCH-1:0]),
        .evt     (evt),
        .mask_o  (mask),
        .raw_o   (raw),
        .irq_o   (irq_o)
    );

    always_comb begin
        rdata = '0;
        if (slot == '0) begin
            unique case (word)
                2'd0:    rdata = DATA_W'(mask);
                2'd1:    rdata = DATA_W'(raw);
                2'd2:    rdata = DATA_W'(raw & mask);
                default: rdata = '0;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                unique case (word)
                    2'd1:    rdata = cnt[i];
                    2'd2:    rdata = DATA_W'(ctl[i]);
                    default: rdata = bg[i];
                endcase
            end
        end
    end

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ((raw & mask) != '0));
endmodule

// File: tb/mct_timer_unit_tb_top.sv
`timescale 1ns/10ps
module mct_timer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mct_timer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    localparam logic [7:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MIS = 8'h08, A_CLR = 8'h0C;
    function automatic logic [7:0] a_ld (int n);  return 8'(8'h10 + 16*n);      endfunction
    function automatic logic [7:0] a_val(int n);  return 8'(8'h10 + 16*n + 4);  endfunction
    function automatic logic [7:0] a_ctl(int n);  return 8'(8'h10 + 16*n + 8);  endfunction
    function automatic logic [7:0] a_bg (int n);  return 8'(8'h10 + 16*n + 12); endfunction

    // expected count just after an event; mode 0 free, 1 periodic, 2 one-shot
    function automatic logic [31:0] after_evt(int mode, logic [31:0] ld, bit wide);
        if (mode == 2) return 32'h0;
        if (mode == 1) return ld;
        return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction
    function automatic logic [7:0] ctl_of(int mode);
        return 8'h82 | (mode == 1 ? 8'h40 : 8'h00) | (mode == 2 ? 8'h01 : 8'h00);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #0.1;
        v = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic off_all();
        for (int c = 0; c < 4; c++) wr(a_ctl(c), 32'h0);
        wr(A_CLR, 32'hF);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk_rd("R1 mask", A_MASK, 0);
        chk_rd("R1 raw", A_RAW, 0);
        chk_rd("R1 val0", a_val(0), 0);
        chk_rd("R1 ctl3", a_ctl(3), 0);
        chk("R1 irq", {31'b0, irq_o}, 0);

        // R2 control keeps only defined bits, clear reads zero
        wr(a_ctl(3), 32'hFFFF_FFFF);
        chk_rd("R2 ctl bits", a_ctl(3), 32'h0000_00CF);
        chk_rd("R2 clr reads zero", A_CLR, 0);
        off_all();

        // R3 load sets count and reload; R9 16-bit read view
        wr(a_ld(2), 32'h1234_5678);
        chk_rd("R9 16-bit view", a_val(2), 32'h0000_5678);
        chk_rd("R3 load readback", a_ld(2), 32'h1234_5678);
        chk_rd("R3 reload copy", a_bg(2), 32'h1234_5678);

        // R4 reload write affects only next wrap
        wr(a_ld(0), 3);
        wr(a_ctl(0), 32'hC2);
        wr(a_bg(0), 5);
        chk_rd("R4 count untouched", a_val(0), 2);
        wait_n(2);
        chk_rd("R6 no event at zero", A_RAW, 0);
        wait_n(1);
        chk_rd("R7 periodic reload", a_val(0), 5);
        chk_rd("R6 event set", A_RAW, 1);
        wr(A_CLR, 1);
        wait_n(4);
        chk_rd("R4 second period early", A_RAW, 0);
        wait_n(1);
        chk_rd("R4 second period", A_RAW, 1);
        off_all();

        // R5 divide by 16
        wr(a_ld(1), 2);
        wr(a_ctl(1), 32'h86);
        wait_n(15);
        chk_rd("R5 div16 before tick", a_val(1), 2);
        wait_n(1);
        chk_rd("R5 div16 first tick", a_val(1), 1);
        wait_n(31);
        chk_rd("R5 div16 pre-event", A_RAW, 0);
        wait_n(1);
        chk_rd("R5 div16 event", A_RAW, 2);
        chk_rd("R7 free wrap 32", a_val(1), 32'hFFFF_FFFF);
        off_all();

        // R5 divide by 256, codes 10 and 11
        for (int k = 0; k < 2; k++) begin
            wr(a_ld(2), 0);
            wr(a_ctl(2), k == 0 ? 32'h8A : 32'h8E);
            wait_n(255);
            chk_rd("R5 div256 pre-event", A_RAW, 0);
            wait_n(1);
            chk_rd("R5 div256 event", A_RAW, 4);
            off_all();
        end

        // R9 16-bit free run and 16-bit zero detect
        wr(a_ld(3), 1);
        wr(a_ctl(3), 32'h80);
        wait_n(2);
        chk_rd("R9 wrap 0xFFFF", a_val(3), 32'h0000_FFFF);
        chk_rd("R9 event", A_RAW, 8);
        off_all();
        wr(a_ld(3), 32'h0001_0000);
        wr(a_ctl(3), 32'h80);
        wait_n(1);
        chk_rd("R9 zero on low half", A_RAW, 8);
        off_all();

        // R8 one-shot
        wr(a_ld(0), 2);
        wr(a_ctl(0), 32'h83);
        wait_n(3);
        chk_rd("R8 one-shot event", A_RAW, 1);
        wr(A_CLR, 1);
        wait_n(20);
        chk_rd("R8 no repeat", A_RAW, 0);
        chk_rd("R8 parked at zero", a_val(0), 0);
        wr(a_ld(0), 1);
        wait_n(2);
        chk_rd("R8 resumed by load", A_RAW, 1);
        off_all();

        // R10 disable freezes
        wr(a_ld(1), 10);
        wr(a_ctl(1), 32'h82);
        wait_n(3);
        chk_rd("R10 running", a_val(1), 7);
        wr(a_ctl(1), 32'h02);
        wait_n(10);
        chk_rd("R10 frozen", a_val(1), 6);
        off_all();

        // R11/R12 with a channel raising an event every cycle
        wr(a_ld(2), 0);
        wr(a_ctl(2), 32'hC2);
        chk_rd("R11 masked off", A_MIS, 0);
        chk("R11 irq low", {31'b0, irq_o}, 0);
        wr(A_MASK, 4);
        chk_rd("R11 masked on", A_MIS, 4);
        chk("R11 irq high", {31'b0, irq_o}, 1);
        wr(A_MASK, 32'hB);
        chk_rd("R11 other mask", A_MIS, 0);
        chk("R11 irq low again", {31'b0, irq_o}, 0);
        wr(A_CLR, 4);
        chk_rd("R12 set wins", A_RAW, 4);
        wr(a_ctl(2), 0);
        wr(A_CLR, 4);
        chk_rd("R12 cleared", A_RAW, 0);
        wr(A_MASK, 0);
        off_all();

        // random loads and modes, div1, 32-bit
        for (int it = 0; it < 24; it++) begin
            int          ch;
            int          mode;
            logic [31:0] ld;
            ch   = int'($urandom_range(0, 3));
            mode = int'($urandom_range(0, 2));
            ld   = 32'($urandom_range(0, 30));
            wr(a_ctl(ch), 0);
            wr(A_CLR, 32'hF);
            wr(a_ld(ch), ld);
            wr(a_ctl(ch), 32'(ctl_of(mode)));
            wait_n(int'(ld));
            chk_rd("R6 random pre-event", A_RAW, 0);
            wait_n(1);
            chk_rd("R6 random event", A_RAW, 32'(1 << ch));
            rd(a_val(ch), v);
            chk(mode == 2 ? "R8 random one-shot" : "R7 random wrap", v, after_evt(mode, ld, 1'b1));
            wr(a_ctl(ch), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule